// File: doc/BRIEF.md
# Link Relay Station with Two-Slot Skid Storage

This block is a registered repeater placed on a router-to-router link. It breaks a long wire into one clocked stage and adds a little buffering. Both faces use the routers' own link handshake: a valid bit travels forward with each flit, and a back-pressure bit travels backward. A transfer happens on a clock edge when the sender drives valid and the receiver's back-pressure is low. The station can therefore be dropped onto any link without resizing the router input queues. Its two flit slots add to the link's storage.

A flit that the next hop refuses is never dropped. The station keeps presenting it until it is taken. Back-pressure goes upstream only when both slots are full. When the station holds one flit and the downstream side stalls, it can still take one more flit. With no stall the station passes one flit per cycle with one cycle of added latency.

The controller has three named states. In EMPTY the output is idle. In ONE the head slot presents a flit. In TWO both slots are full and back-pressure is raised. The transitions are:
- FILL: EMPTY to ONE, when a flit is accepted.
- FLOW: ONE to ONE, when a flit arrives and one leaves, or when nothing moves.
- SKID: ONE to TWO, when a flit arrives while the output is stalled.
- DRAIN: ONE to EMPTY, when the output is taken and no flit arrives.
- PROMOTE: TWO to ONE, when the output is taken and the spare flit moves to the head.
- In TWO with the output stalled, the state holds.

Top module: `relay_station`

## Requirements
- R1: After reset, or whenever reset is asserted, `dn_valid` is 0 and `up_stall` is 0.
- R2: A flit accepted while the station is empty appears on `dn_flit` with `dn_valid` high in the next cycle, with exactly one cycle of added latency.
- R3: While `dn_stall` stays low, a back-to-back upstream stream is accepted at one flit per cycle, and `up_stall` never rises.
- R4: While `dn_valid` is high and `dn_stall` is high, `dn_valid` stays high and `dn_flit` is unchanged in the next cycle.
- R5: `up_stall` is high exactly when two accepted flits are held. With one flit held and `dn_stall` high, a second offered flit is accepted.
- R6: A flit offered while `up_stall` is high is not taken. It never appears downstream unless it is offered again later.
- R7: Flits leave in the order they were accepted. None is duplicated or dropped under any pattern of downstream stalls.
- R8: When the station is full and the downstream side accepts a flit, `up_stall` is low in the next cycle.
- R9: When no flit is held, `dn_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_flit | input | FLIT_W | Flit from the upstream hop |
| up_valid | input | 1 | Upstream flit is valid |
| up_stall | output | 1 | Back-pressure to upstream: both slots are full |
| dn_flit | output | FLIT_W | Flit to the downstream hop |
| dn_valid | output | 1 | Downstream flit is valid |
| dn_stall | input | 1 | Back-pressure from downstream |

## Verification
The main function is exercised with five stimulus patterns:
- An unstalled back-to-back stream. This separates a true one-per-cycle pipeline from one that inserts bubbles or raises back-pressure too early.
- A stall that arrives with one flit held. This shows whether the second slot absorbs the in-flight flit or whether the station pushes back at once.
- A stall held while a third flit is offered. This shows whether a refused flit is wrongly taken.
- A stall released from full. This shows whether the spare flit, and not a stale or new one, moves to the head.
- A long stream under periodic stalls, checked against the order in which flits were sent. This catches any drop or duplicate.

// File: rtl/relay_pkg.sv
package relay_pkg;

    typedef enum logic [1:0] {
        SLOTS_EMPTY = 2'd0,
        SLOTS_ONE   = 2'd1,
        SLOTS_TWO   = 2'd2
    } slot_state_e;

    typedef enum logic [1:0] {
        HEAD_HOLD = 2'd0,
        HEAD_TAKE_IN = 2'd1,
        HEAD_TAKE_SPARE = 2'd2
    } head_sel_e;

endpackage

// File: rtl/relay_ctrl.sv
module relay_ctrl
    import relay_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      up_valid,
    input  logic      dn_stall,
    output logic      up_stall,
    output logic      dn_valid,
    output head_sel_e head_sel,
    output logic      spare_load
);

    slot_state_e state_q, state_d;
    logic take_in;
    logic give_out;

    // Handshake qualifiers, derived from the current state only
    always_comb begin
        take_in  = up_valid && (state_q != SLOTS_TWO);
        give_out = (state_q != SLOTS_EMPTY) && !dn_stall;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOTS_EMPTY;
        else        state_q <= state_d;
    end

    // Next state and datapath steering
    always_comb begin
        state_d    = state_q;
        head_sel   = HEAD_HOLD;
        spare_load = 1'b0;
        unique case (state_q)
            SLOTS_EMPTY: begin
                if (take_in) begin           // FILL
                    state_d  = SLOTS_ONE;
                    head_sel = HEAD_TAKE_IN;
                end
            end
            SLOTS_ONE: begin
                if (take_in && give_out) begin        // FLOW
                    head_sel = HEAD_TAKE_IN;
                end else if (take_in) begin           // SKID
                    state_d    = SLOTS_TWO;
                    spare_load = 1'b1;
                end else if (give_out) begin          // DRAIN
                    state_d = SLOTS_EMPTY;
                end
            end
            SLOTS_TWO: begin
                if (give_out) begin                   // PROMOTE
                    state_d  = SLOTS_ONE;
                    head_sel = HEAD_TAKE_SPARE;
                end
            end
            default: state_d = SLOTS_EMPTY;
        endcase
    end

    // Outputs from the state register
    always_comb begin
        dn_valid = (state_q != SLOTS_EMPTY);
        up_stall = (state_q == SLOTS_TWO);
    end

endmodule

// File: rtl/relay_slots.sv
module relay_slots
    import relay_pkg::*;
#(
    parameter int FLIT_W     = 32,
    parameter bit CLEAR_DATA = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLIT_W-1:0] in_flit,
    input  head_sel_e         head_sel,
    input  logic              spare_load,
    output logic [FLIT_W-1:0] head_flit
);

    localparam logic [FLIT_W-1:0] ZERO_FLIT = '0;

    logic [FLIT_W-1:0] head_q, spare_q, head_d;

    always_comb begin
        unique case (head_sel)
            HEAD_TAKE_IN:    head_d = in_flit;
            HEAD_TAKE_SPARE: head_d = spare_q;
            default:         head_d = head_q;
        endcase
    end

    generate
        if (CLEAR_DATA) begin : g_clear
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    head_q  <= ZERO_FLIT;
                    spare_q <= ZERO_FLIT;
                end else begin
                    head_q <= head_d;
                    if (spare_load) spare_q <= in_flit;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                head_q <= head_d;
                if (spare_load) spare_q <= in_flit;
            end
        end
    endgenerate

    assign head_flit = head_q;

endmodule

// File: rtl/relay_station.sv
module relay_station
    import relay_pkg::*;
#(
    parameter int FLIT_W     = 32,
    parameter bit CLEAR_DATA = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLIT_W-1:0] up_flit,
    input  logic              up_valid,
    output logic              up_stall,
    output logic [FLIT_W-1:0] dn_flit,
    output logic              dn_valid,
    input  logic              dn_stall
);

    head_sel_e head_sel;
    logic      spare_load;

    relay_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_valid   (up_valid),
        .dn_stall   (dn_stall),
        .up_stall   (up_stall),
        .dn_valid   (dn_valid),
        .head_sel   (head_sel),
        .spare_load (spare_load)
    );

    relay_slots #(
        .FLIT_W     (FLIT_W),
        .CLEAR_DATA (CLEAR_DATA)
    ) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_flit    (up_flit),
        .head_sel   (head_sel),
        .spare_load (spare_load),
        .head_flit  (dn_flit)
    );

endmodule

// File: rtl/relay_station_chk.sv
module relay_station_chk #(
    parameter int FLIT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FLIT_W-1:0] up_flit,
    input logic              up_valid,
    input logic              up_stall,
    input logic [FLIT_W-1:0] dn_flit,
    input logic              dn_valid,
    input logic              dn_stall
);

    logic [1:0] occ;

    // Occupancy rebuilt from the port handshakes alone
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ <= 2'd0;
        else occ <= occ + 2'(up_valid && !up_stall) - 2'(dn_valid && !dn_stall);
    end

    // R9
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == 2'd0) |-> !dn_valid);

    // R5
    stall_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_stall == (occ == 2'd2));

    // R4
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && dn_stall) |=> (dn_valid && $stable(dn_flit)));

    // R2
    one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == 2'd0 && up_valid) |=> (dn_valid && dn_flit == $past(up_flit)));

    // R8
    release_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_stall && dn_valid && !dn_stall) |=> !up_stall);

endmodule

bind relay_station relay_station_chk #(.FLIT_W(FLIT_W)) u_chk (.*);

// File: tb/relay_station_test.sv
module relay_station_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] up_flit = '0;
    logic         up_valid = 1'b0;
    logic         up_stall;
    logic [W-1:0] dn_flit;
    logic         dn_valid;
    logic         dn_stall = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    relay_station #(.FLIT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .up_flit(up_flit), .up_valid(up_valid),
        .up_stall(up_stall), .dn_flit(dn_flit), .dn_valid(dn_valid), .dn_stall(dn_stall)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Vector: {req, uv, flit, ds, exp_dv, exp_flit, exp_stall}; expected values are
    // the outputs seen while this vector's inputs are applied (before the edge).
    localparam int NV = 13;
    localparam int VEC [NV][7] = '{
        '{1, 1, 'h11, 0, 0, 'h00, 0},   // R1 idle after reset
        '{2, 1, 'h22, 0, 1, 'h11, 0},   // R2 one cycle later
        '{3, 1, 'h33, 1, 1, 'h22, 0},   // R3 back-to-back
        '{5, 1, 'h44, 1, 1, 'h22, 1},   // R5 second slot absorbed 33
        '{6, 1, 'h44, 0, 1, 'h22, 1},   // R6 44 refused while full
        '{8, 1, 'h44, 0, 1, 'h33, 0},   // R8 released after drain
        '{4, 0, 'h00, 1, 1, 'h44, 0},   // R4 hold begins
        '{4, 0, 'h00, 0, 1, 'h44, 0},   // R4 still held
        '{9, 1, 'h55, 1, 0, 'h00, 0},   // R9 empty
        '{2, 1, 'h66, 1, 1, 'h55, 0},   // R2 fill despite stall
        '{5, 0, 'h00, 0, 1, 'h55, 1},   // R5 full
        '{7, 0, 'h00, 0, 1, 'h66, 0},   // R7 order kept
        '{9, 0, 'h00, 0, 0, 'h00, 0}    // R9 empty again
    };

    task automatic stream(input int n, input int stall_period, input string req);
        int sent = 0;
        int got = 0;
        bit saw_stall = 1'b0;
        for (int cyc = 0; cyc < 4 * n + 20 && got < n; cyc++) begin
            @(negedge clk);
            if (dn_valid && !dn_stall) begin
                check(req, "stream order", int'(dn_flit), (got + 8'h80) & 8'hFF);
                got++;
            end
            if (up_valid && !up_stall) sent++;
            if (up_stall) saw_stall = 1'b1;
            #1;
            up_valid = (sent < n);
            up_flit  = W'(sent + 8'h80);
            dn_stall = (stall_period > 0) && (cyc % stall_period == stall_period - 1);
        end
        up_valid = 1'b0;
        dn_stall = 1'b0;
        check(req, "stream count", got, n);
        if (stall_period == 0) check("R3", "no back-pressure unstalled", int'(saw_stall), 0);
        @(negedge clk);
        check(req, "no extra flit", int'(dn_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "dn_valid in reset", int'(dn_valid), 0);
        check("R1", "up_stall in reset", int'(up_stall), 0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check($sformatf("R%0d", VEC[i][0]), "dn_valid", int'(dn_valid), VEC[i][4]);
            if (VEC[i][4] != 0)
                check($sformatf("R%0d", VEC[i][0]), "dn_flit", int'(dn_flit), VEC[i][5]);
            check($sformatf("R%0d", VEC[i][0]), "up_stall", int'(up_stall), VEC[i][6]);
            up_valid = VEC[i][1][0];
            up_flit  = W'(VEC[i][2]);
            dn_stall = VEC[i][3][0];
        end
        @(negedge clk);
        up_valid = 1'b0;
        dn_stall = 1'b0;
        // R3 unstalled stream
        stream(10, 0, "R3");
        // R7 periodic stalls
        stream(40, 3, "R7");
        stream(30, 2, "R7");
        // R1 reset while full
        up_valid = 1'b1; up_flit = 8'hA1; dn_stall = 1'b1;
        repeat (3) @(negedge clk);
        check("R5", "full before reset", int'(up_stall), 1);
        rst_n = 1'b0;
        #1;
        check("R1", "dn_valid async reset", int'(dn_valid), 0);
        check("R1", "up_stall async reset", int'(up_stall), 0);
        up_valid = 1'b0; dn_stall = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "empty after reset", int'(dn_valid), 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule